// File: doc/BRIEF.md
# Five-Level Stacked-Carrier Modulator with Capacitor Balancing

This block generates the six gate signals of a single-phase five-level inverter made of two series capacitors and three complementary switch pairs. A signed reference sample is compared against four triangular carriers. The carriers share one up/down counter and are offset by one band each. The number of carriers the reference reaches gives one of five output levels (−2, −1, 0, +1, +2 capacitor steps).

Each level is then turned into a switching state (S1,S2,S3). The zero level and both single-step levels can each be built in two ways. For the single-step levels, the choice depends on the sign of the inverter current and on which capacitor voltage is lower, so that charge moves toward the lower capacitor. For the zero level, the choice follows the reference sign, so the centre pair changes only at the fundamental rate. The decision about which capacitor is lower is taken only at carrier turning points. Each complementary pair passes through a programmable dead interval before any change.

Top module: `five_level_pwm`

## Requirements
- R1: While reset is high at a clock edge, all six gate outputs (`gate`, `gate_n`) are low from that edge on.
- R2: When the level is +2, the state (S1,S2,S3) is 010. When the level is −2, the state is 101. Neither of these states depends on the balancing inputs. `gate[k-1]` carries Sk.
- R3: The zero level uses state 111 when the reference is zero or positive, and 000 when it is negative. S2 is therefore the inverse of the reference sign bit.
- R4: With `bal_en` low, level +1 always uses 011 and level −1 always uses 100. States 110 and 001 never appear.
- R5: With `bal_en` high: level +1 uses 011 (capacitor 1) or 110 (capacitor 2), and level −1 uses 100 (capacitor 1) or 001 (capacitor 2). Capacitor 1 is chosen when (level +1 and `i_pos`=1 and capacitor 1 not lower), or (level +1 and `i_pos`=0 and capacitor 1 lower), or (level −1 and `i_pos`=1 and capacitor 1 lower), or (level −1 and `i_pos`=0 and capacitor 1 not lower). Capacitor 1 counts as lower when `vc1 < vc2` (unsigned).
- R6: The lower-capacitor decision is loaded only on a clock edge where the carrier counter is at a turning point (at or above `period` while counting up, or 0 while counting down). At all other edges it holds its value.
- R7: `gate[i]` and `gate_n[i]` are never both high.
- R8: When a pair's target differs from its driven value, both of its gates go low for `dead`+1 cycles. The new value is driven on the following cycle. With no pending change, `gate_n[i]` is the inverse of `gate[i]`.
- R9: The carrier counter c rises by one per clock from 0 to `period`, then falls back to 0. The level is (number of k in 0..3 with ref ≥ (k−2)·period + c) − 2. The target state is registered one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | W | Signed reference; one level band equals `period` counts |
| i_pos | input | 1 | Inverter current sign, 1 = flowing out of the output terminal |
| vc1 | input | VW | Capacitor 1 voltage code, unsigned |
| vc2 | input | VW | Capacitor 2 voltage code, unsigned |
| bal_en | input | 1 | Enables redundant-state balancing |
| period | input | CW | Carrier peak count, at least 1 |
| dead | input | DW | Dead interval length minus one, in cycles |
| gate | output | 3 | Primary gates, bit k-1 = Sk |
| gate_n | output | 3 | Complementary gates |

## Verification
A stepped reference sweep across the whole range, with balancing off, tells the four carrier bands apart and shows that only the default single-step states appear. The same sweep is repeated with balancing on under all four combinations of current sign and capacitor ordering. Each combination selects a different member of the redundant pairs, which exposes a swapped rule. The capacitor ordering is also toggled every few cycles, so that a decision updated outside the carrier turning points shows up against the reference model. Runs with zero and long dead intervals separate gap-length errors. Held extreme references give the fixed ±2 states.

// File: rtl/five_level_pwm.sv
module five_level_pwm #(
  parameter int W  = 16,
  parameter int CW = 10,
  parameter int VW = 12,
  parameter int DW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] ref_in,
  input  logic                i_pos,
  input  logic [VW-1:0]       vc1,
  input  logic [VW-1:0]       vc2,
  input  logic                bal_en,
  input  logic [CW-1:0]       period,
  input  logic [DW-1:0]       dead,
  output logic [2:0]          gate,
  output logic [2:0]          gate_n
);
  localparam int XW = W + 2;

  logic [CW-1:0] cnt_q;
  logic          up_q, low1_q, at_turn;
  logic [2:0]    st_q, st_d;
  logic [2:0]    nlev;
  logic          use_c1;
  logic signed [XW-1:0] rx, px, cx, th0, th1, th2, th3;
  logic h0, h1, h2, h3;

  assign at_turn = up_q ? (cnt_q >= period) : (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= period) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cnt_q == '0) begin
      up_q  <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          low1_q <= 1'b0;
    else if (at_turn) low1_q <= (vc1 < vc2);
  end

  // R6
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (low1_q != $past(low1_q)) |-> $past(at_turn));

  assign rx  = {{2{ref_in[W-1]}}, ref_in};
  assign px  = $signed({{(XW-CW){1'b0}}, period});
  assign cx  = $signed({{(XW-CW){1'b0}}, cnt_q});
  assign th0 = cx - px - px;
  assign th1 = cx - px;
  assign th2 = cx;
  assign th3 = cx + px;
  assign h0  = (rx >= th0);
  assign h1  = (rx >= th1);
  assign h2  = (rx >= th2);
  assign h3  = (rx >= th3);
  assign nlev = {2'b0, h0} + {2'b0, h1} + {2'b0, h2} + {2'b0, h3};

  always_comb begin
    use_c1 = 1'b1;
    if (bal_en) begin
      if (nlev == 3'd3) use_c1 = i_pos ? ~low1_q : low1_q;
      else              use_c1 = i_pos ? low1_q : ~low1_q;
    end
  end

  // st_d holds {S1,S2,S3}
  always_comb begin
    case (nlev)
      3'd4:    st_d = 3'b010;
      3'd3:    st_d = use_c1 ? 3'b011 : 3'b110;
      3'd2:    st_d = ref_in[W-1] ? 3'b000 : 3'b111;
      3'd1:    st_d = use_c1 ? 3'b100 : 3'b001;
      default: st_d = 3'b101;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= 3'b000;
    else     st_q <= st_d;
  end

  // R4
  default_state_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bal_en) |-> (st_q != 3'b110 && st_q != 3'b001));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (gate == 3'b000 && gate_n == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_pair
    logic          tgt, cur_q, live_q, hi_q, lo_q;
    logic [DW-1:0] dt_q;

    assign tgt = st_q[2-i];

    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q  <= 1'b0;
        live_q <= 1'b0;
        dt_q   <= '0;
        hi_q   <= 1'b0;
        lo_q   <= 1'b0;
      end else if (tgt != cur_q || !live_q) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
        if (dt_q == dead) begin
          cur_q  <= tgt;
          live_q <= 1'b1;
          dt_q   <= '0;
        end else begin
          dt_q <= dt_q + 1'b1;
        end
      end else begin
        hi_q <= cur_q;
        lo_q <= ~cur_q;
        dt_q <= '0;
      end
    end

    assign gate[i]   = hi_q;
    assign gate_n[i] = lo_q;

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      !(gate[i] && gate_n[i]));

    // R8
    gap_before_hi_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(gate[i]) |-> $past(!gate[i] && !gate_n[i]));

    // R8
    gap_before_lo_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_n[i]) |-> $past(!gate[i] && !gate_n[i]));
  end
endmodule

// File: tb/test_five_level_pwm.sv
module test_five_level_pwm;
  localparam int CLK_P = 10;
  localparam int W = 16, CW = 10, VW = 12, DW = 4;
  localparam int PER = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0] ref_in;
  logic i_pos, bal_en;
  logic [VW-1:0] vc1, vc2;
  logic [CW-1:0] period;
  logic [DW-1:0] dead;
  logic [2:0] gate, gate_n;

  int ref_r = 0, ip_r = 0, bal_r = 0, v1_r = 100, v2_r = 120, dead_r = 2;
  int vectors = 0, fails = 0;
  int n110 = 0, n001 = 0, n111 = 0, n000 = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign ref_in = ref_r[W-1:0];
  assign i_pos  = ip_r[0];
  assign bal_en = bal_r[0];
  assign vc1    = v1_r[VW-1:0];
  assign vc2    = v2_r[VW-1:0];
  assign period = PER[CW-1:0];
  assign dead   = dead_r[DW-1:0];

  five_level_pwm #(.W(W), .CW(CW), .VW(VW), .DW(DW)) i_five_level_pwm (
    .clk(clk), .rst(rst), .ref_in(ref_in), .i_pos(i_pos), .vc1(vc1), .vc2(vc2),
    .bal_en(bal_en), .period(period), .dead(dead), .gate(gate), .gate_n(gate_n));

  // behavioural reference model
  int m_c = 0, m_up = 1, m_low1 = 0;
  int m_s[3] = '{0, 0, 0};
  int m_cur[3] = '{0, 0, 0};
  int m_live[3] = '{0, 0, 0};
  int m_dt[3] = '{0, 0, 0};
  int m_hi[3] = '{0, 0, 0};
  int m_lo[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (rst) begin
      m_c = 0; m_up = 1; m_low1 = 0;
      for (int i = 0; i < 3; i++) begin
        m_s[i] = 0; m_cur[i] = 0; m_live[i] = 0; m_dt[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
      end
    end else begin
      int n, c1, turn;
      for (int i = 0; i < 3; i++) begin
        if (m_s[i] != m_cur[i] || m_live[i] == 0) begin
          m_hi[i] = 0; m_lo[i] = 0;
          if (m_dt[i] == dead_r) begin
            m_cur[i] = m_s[i]; m_live[i] = 1; m_dt[i] = 0;
          end else m_dt[i]++;
        end else begin
          m_hi[i] = m_cur[i]; m_lo[i] = 1 - m_cur[i]; m_dt[i] = 0;
        end
      end
      n = 0;
      for (int k = 0; k < 4; k++) if (ref_r >= (k - 2) * PER + m_c) n++;
      c1 = 1;
      if (bal_r != 0) begin
        if (n == 3) c1 = (ip_r != 0) ? 1 - m_low1 : m_low1;
        else        c1 = (ip_r != 0) ? m_low1 : 1 - m_low1;
      end
      case (n)
        4: m_s = '{0, 1, 0};
        3: m_s = c1 ? '{0, 1, 1} : '{1, 1, 0};
        2: m_s = (ref_r >= 0) ? '{1, 1, 1} : '{0, 0, 0};
        1: m_s = c1 ? '{1, 0, 0} : '{0, 0, 1};
        default: m_s = '{1, 0, 1};
      endcase
      turn = (m_up != 0) ? (m_c >= PER) : (m_c == 0);
      if (turn) m_low1 = (v1_r < v2_r) ? 1 : 0;
      if (m_up != 0) begin
        if (m_c >= PER) begin m_up = 0; m_c--; end else m_c++;
      end else if (m_c == 0) begin m_up = 1; m_c++; end
      else m_c--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [2:0] eg, en;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      eg[i] = m_hi[i][0];
      en[i] = m_lo[i][0];
    end
    chk({gate, gate_n} == {eg, en}, "R2/R3/R4/R5/R6/R8/R9 gate,gate_n", {gate, gate_n}, {eg, en});
    // R7
    chk((gate & gate_n) == 3'b000, "R7 overlap", {gate, gate_n}, {gate, ~gate});
    if (gate_n == ~gate) begin
      if (gate == 3'b011) n110++;
      if (gate == 3'b100) n001++;
      if (gate == 3'b111) n111++;
      if (gate == 3'b000) n000++;
    end
  endtask

  task automatic sweep(input int hold);
    for (int r = -2 * PER - 2; r <= 2 * PER + 2; r++) begin
      ref_r = r;
      repeat (hold) step();
    end
  endtask

  initial begin
    repeat (3) step();
    // R1
    chk(gate == 0 && gate_n == 0, "R1 reset", {gate, gate_n}, 6'b0);
    rst = 1'b0;

    bal_r = 0;
    sweep(20);
    // R4
    chk(n110 == 0 && n001 == 0, "R4 no alternate states", {n110[2:0], n001[2:0]}, 6'b0);

    bal_r = 1;
    for (int ip = 0; ip < 2; ip++)
      for (int ord = 0; ord < 2; ord++) begin
        ip_r = ip;
        v1_r = ord ? 130 : 100;
        v2_r = 115;
        sweep(20);
      end
    // R5
    chk(n110 > 0 && n001 > 0, "R5 alternate states used", {n110 > 0, n001 > 0, 4'b0}, 6'b110000);
    // R3
    chk(n111 > 0 && n000 > 0, "R3 both zero states used", {n111 > 0, n000 > 0, 4'b0}, 6'b110000);

    // R6: capacitor ordering toggled inside carrier periods
    for (int r = -2 * PER - 2; r <= 2 * PER + 2; r++) begin
      ref_r = r;
      for (int t = 0; t < 4; t++) begin
        v1_r = (v1_r == 100) ? 130 : 100;
        ip_r = t & 1;
        repeat (3) step();
      end
    end

    // R8: dead interval variants
    dead_r = 0;
    sweep(10);
    dead_r = 5;
    sweep(14);
    dead_r = 2;

    // R2
    ref_r = 2 * PER;
    repeat (30) step();
    chk(gate == 3'b010 && gate_n == 3'b101, "R2 +2 level", {gate, gate_n}, 6'b010101);
    ref_r = -2 * PER - 1;
    repeat (30) step();
    chk(gate == 3'b101 && gate_n == 3'b010, "R2 -2 level", {gate, gate_n}, 6'b101010);

    // R1 mid-run reset
    rst = 1'b1;
    step();
    chk(gate == 0 && gate_n == 0, "R1 reset mid-run", {gate, gate_n}, 6'b0);
    rst = 1'b0;
    ref_r = 3;
    repeat (40) step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule